// File: doc/BRIEF.md
# Fractional Baud-Rate Divisor Generator

This block derives a 16x oversampling tick for an asynchronous serial engine from the system clock. The rate is set by a 16-bit integer divisor and a 6-bit fractional divisor counted in 64ths of a clock. A 6-bit accumulator adds the fraction once per tick period. Each carry out of that accumulator adds one clock to the next period, so that over 64 periods the mean period is the integer divisor plus fraction/64 clocks.

Software writes both divisors into staging registers, and the staged values can be read back. Staged values have no effect on timing until the line-control write strobe arrives. That strobe requests a commit. The commit happens at once if the serial engine is idle. Otherwise it waits for the engine's character-done pulse, so that a character in flight never changes rate part-way through. A pending flag shows a request that is still waiting. A commit restarts the period counter and clears the accumulator.

No data stream passes through this block, so it has no valid/ready handshake. Every pin is a plain control or status signal, sampled or driven on the rising clock edge. Back-pressure does not apply.

Top module: `fracbaud_gen`

## Requirements
- R1: After reset, `tick` and `upd_pending` are 0, both readback ports read 0, and no tick is produced, because the active integer divisor resets to 0.
- R2: One cycle after a write, `frac_rdata[5:0]` returns the staged fraction and `frac_rdata[31:6]` reads 0. `int_rdata` returns the staged 16-bit integer divisor.
- R3: Writing the integer or fractional divisor without a line-control strobe leaves the tick period unchanged.
- R4: A line-control strobe sampled while `char_busy` is 0 commits at that same edge, and `upd_pending` stays 0.
- R5: A line-control strobe sampled while `char_busy` is 1 sets `upd_pending` from the next cycle. The old rate continues until an edge where `char_done` is 1. The staged values are committed at that edge, and `upd_pending` returns to 0.
- R6: `tick` is a one-clock pulse. With fraction 0 and integer divisor N ≥ 1, ticks are N clocks apart.
- R7: Period k after a commit (k ≥ 1) lasts N + c clocks. Here c is the carry out of the k-th 6-bit addition of the fraction F into an accumulator that starts at 0. Period 0 lasts N clocks. Periods 1 to 64 therefore total 64·N + F clocks.
- R8: While the active integer divisor is 0, `tick` stays 0.
- R9: A commit restarts timing: `tick` is 0 in the cycle after the commit edge, and the first tick rises N clocks after it.
- R10: A divisor write sampled at the same edge as a committing strobe is included in that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_wr | input | 1 | Write strobe for the staged integer divisor |
| int_wdata | input | 16 | Integer divisor write data |
| frac_wr | input | 1 | Write strobe for the staged fractional divisor |
| frac_wdata | input | 6 | Fractional divisor write data, in 64ths |
| lc_wr | input | 1 | Line-control write strobe; requests a commit |
| char_busy | input | 1 | Serial engine is in the middle of a character |
| char_done | input | 1 | One-cycle pulse at the end of a character |
| int_rdata | output | 16 | Staged integer divisor readback |
| frac_rdata | output | 32 | Staged fraction readback in bits 5:0; bits 31:6 are zero |
| tick | output | 1 | One-clock oversampling tick |
| upd_pending | output | 1 | A commit request is waiting for the character to end |

## Verification
Readback is due one cycle after a write edge. `upd_pending` reflects a strobe one cycle after the edge that samples it. The first tick after a commit rises N clocks after the commit edge, and later ticks follow at the R7 period. The bench drives inputs and samples outputs at falling edges. It counts falling edges from the strobe edge, so a tick seen at count c gives an interval of c minus the previous count. These intervals are compared with a period model computed independently from the fraction and integer divisor.

// File: rtl/fracbaud_pkg.sv
package fracbaud_pkg;
  localparam int FB_INT_W  = 16;
  localparam int FB_FRAC_W = 6;
  localparam int FB_RD_W   = 32;

  typedef enum logic {
    FB_IDLE = 1'b0,
    FB_WAIT = 1'b1
  } fb_upd_e;
endpackage

// File: rtl/fbd_stage_regs.sv
module fbd_stage_regs #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int RD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_wr,
  input  logic [INT_W-1:0]  int_wdata,
  input  logic              frac_wr,
  input  logic [FRAC_W-1:0] frac_wdata,
  output logic [INT_W-1:0]  stg_int_nx,
  output logic [FRAC_W-1:0] stg_frac_nx,
  output logic [INT_W-1:0]  int_rdata,
  output logic [RD_W-1:0]   frac_rdata
);
  localparam int PAD_W = RD_W - FRAC_W;

  logic [INT_W-1:0]  stg_int_q;
  logic [FRAC_W-1:0] stg_frac_q;

  // next-state values are also forwarded so a same-edge commit sees them
  always_comb begin
    stg_int_nx  = int_wr  ? int_wdata  : stg_int_q;
    stg_frac_nx = frac_wr ? frac_wdata : stg_frac_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_int_q  <= '0;
      stg_frac_q <= '0;
    end else begin
      stg_int_q  <= stg_int_nx;
      stg_frac_q <= stg_frac_nx;
    end
  end

  assign int_rdata  = stg_int_q;
  assign frac_rdata = {{PAD_W{1'b0}}, stg_frac_q};
endmodule

// File: rtl/fbd_commit_ctrl.sv
module fbd_commit_ctrl
  import fracbaud_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lc_wr,
  input  logic              char_busy,
  input  logic              char_done,
  input  logic [INT_W-1:0]  stg_int_nx,
  input  logic [FRAC_W-1:0] stg_frac_nx,
  output logic              commit,
  output logic              pending,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac
);
  fb_upd_e st_q, st_d;
  logic    req;
  logic    boundary;

  always_comb begin
    req      = lc_wr || (st_q == FB_WAIT);
    boundary = !char_busy || char_done;
    commit   = req && boundary;
    st_d     = (req && !commit) ? FB_WAIT : FB_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= FB_IDLE;
      act_int  <= '0;
      act_frac <= '0;
    end else begin
      st_q <= st_d;
      if (commit) begin
        act_int  <= stg_int_nx;
        act_frac <= stg_frac_nx;
      end
    end
  end

  assign pending = (st_q == FB_WAIT);
endmodule

// File: rtl/fbd_frac_accum.sv
module fbd_frac_accum #(
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              period_end,
  input  logic [FRAC_W-1:0] frac,
  output logic              stretch
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      stretch <= 1'b0;
    end else if (commit) begin
      acc_q   <= '0;
      stretch <= 1'b0;
    end else if (period_end) begin
      acc_q   <= sum[FRAC_W-1:0];
      stretch <= sum[FRAC_W];
    end
  end
endmodule

// File: rtl/fbd_period_cnt.sv
module fbd_period_cnt #(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [INT_W-1:0] div,
  input  logic             stretch,
  output logic             period_end,
  output logic             tick
);
  localparam int CW = INT_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          run;

  assign run        = (div != '0);
  assign limit      = {1'b0, div} - CW'(1) + CW'(stretch);
  assign period_end = run && !commit && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (commit || !run) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= period_end;
      cnt_q <= period_end ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/fracbaud_gen.sv
module fracbaud_gen
  import fracbaud_pkg::*;
#(
  parameter int INT_W  = FB_INT_W,
  parameter int FRAC_W = FB_FRAC_W,
  parameter int RD_W   = FB_RD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_wr,
  input  logic [INT_W-1:0]  int_wdata,
  input  logic              frac_wr,
  input  logic [FRAC_W-1:0] frac_wdata,
  input  logic              lc_wr,
  input  logic              char_busy,
  input  logic              char_done,
  output logic [INT_W-1:0]  int_rdata,
  output logic [RD_W-1:0]   frac_rdata,
  output logic              tick,
  output logic              upd_pending
);
  logic [INT_W-1:0]  stg_int_nx;
  logic [FRAC_W-1:0] stg_frac_nx;
  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_frac;
  logic              commit;
  logic              stretch;
  logic              period_end;

  fbd_stage_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .RD_W(RD_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_wr     (int_wr),
    .int_wdata  (int_wdata),
    .frac_wr    (frac_wr),
    .frac_wdata (frac_wdata),
    .stg_int_nx (stg_int_nx),
    .stg_frac_nx(stg_frac_nx),
    .int_rdata  (int_rdata),
    .frac_rdata (frac_rdata)
  );

  fbd_commit_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lc_wr      (lc_wr),
    .char_busy  (char_busy),
    .char_done  (char_done),
    .stg_int_nx (stg_int_nx),
    .stg_frac_nx(stg_frac_nx),
    .commit     (commit),
    .pending    (upd_pending),
    .act_int    (act_int),
    .act_frac   (act_frac)
  );

  fbd_frac_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .period_end(period_end),
    .frac      (act_frac),
    .stretch   (stretch)
  );

  fbd_period_cnt #(.INT_W(INT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .div       (act_int),
    .stretch   (stretch),
    .period_end(period_end),
    .tick      (tick)
  );
endmodule

// File: rtl/fracbaud_gen_chk.sv
module fracbaud_gen_chk #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int RD_W   = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lc_wr,
  input logic                   char_busy,
  input logic                   char_done,
  input logic                   tick,
  input logic                   upd_pending,
  input logic                   commit,
  input logic [RD_W-FRAC_W-1:0] rsvd_bits,
  input logic [INT_W-1:0]       act_int,
  input logic [FRAC_W-1:0]      act_frac
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_bits == '0);

  assert_hold_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lc_wr && !upd_pending) |=> ($stable(act_int) && $stable(act_frac)));

  assert_idle_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_wr && !char_busy) |=> !upd_pending);

  assert_wait_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pending && char_busy && !char_done) |=> upd_pending);

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pending && (!char_busy || char_done)) |=> !upd_pending);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act_int > INT_W'(1)) |=> !tick);

  assert_zero_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_int == '0) |-> !tick);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !tick);
endmodule

bind fracbaud_gen fracbaud_gen_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W), .RD_W(RD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lc_wr      (lc_wr),
  .char_busy  (char_busy),
  .char_done  (char_done),
  .tick       (tick),
  .upd_pending(upd_pending),
  .commit     (commit),
  .rsvd_bits  (frac_rdata[RD_W-1:FRAC_W]),
  .act_int    (act_int),
  .act_frac   (act_frac)
);

// File: tb/fracbaud_gen_bench.sv
module fracbaud_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_wr = 1'b0;
  logic [15:0] int_wdata = '0;
  logic        frac_wr = 1'b0;
  logic [5:0]  frac_wdata = '0;
  logic        lc_wr = 1'b0;
  logic        char_busy = 1'b0;
  logic        char_done = 1'b0;
  logic [15:0] int_rdata;
  logic [31:0] frac_rdata;
  logic        tick;
  logic        upd_pending;

  int checks = 0;
  int failures = 0;
  int ivl [0:127];

  // columns: integer divisor, fraction, periods to measure
  localparam int NVEC = 8;
  localparam int VEC [0:NVEC-1][0:2] = '{
    '{4, 0, 5}, '{5, 32, 6}, '{3, 1, 6}, '{2, 63, 8},
    '{7, 16, 8}, '{1, 0, 4}, '{1, 32, 6}, '{9, 48, 6}
  };

  always #4 clk = ~clk;

  fracbaud_gen u_fracbaud_gen (
    .clk(clk), .rst_n(rst_n), .int_wr(int_wr), .int_wdata(int_wdata),
    .frac_wr(frac_wr), .frac_wdata(frac_wdata), .lc_wr(lc_wr),
    .char_busy(char_busy), .char_done(char_done), .int_rdata(int_rdata),
    .frac_rdata(frac_rdata), .tick(tick), .upd_pending(upd_pending)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // period k after a commit, from the stated accumulation rule
  function automatic int exp_period(input int n, input int f, input int k);
    int acc = 0;
    int c = 0;
    for (int i = 1; i <= k; i++) begin
      c   = (acc + f) / 64;
      acc = (acc + f) % 64;
    end
    return n + ((k == 0) ? 0 : c);
  endfunction

  task automatic wr_div(input int n, input int f);
    int_wr = 1'b1; int_wdata = 16'(n);
    frac_wr = 1'b1; frac_wdata = 6'(f);
    @(negedge clk);
    int_wr = 1'b0; frac_wr = 1'b0;
  endtask

  // raise lc_wr or char_done, then record intervals counted from that edge
  task automatic commit_measure(input bit via_done, input int n, input int max_cyc,
                                output int got);
    int prev = 1;
    got = 0;
    if (via_done) char_done = 1'b1; else lc_wr = 1'b1;
    for (int c = 1; c <= max_cyc && got < n; c++) begin
      @(negedge clk);
      lc_wr = 1'b0; char_done = 1'b0; int_wr = 1'b0; frac_wr = 1'b0;
      if (tick) begin
        ivl[got] = c - prev;
        prev = c;
        got++;
      end
    end
  endtask

  task automatic watch_ticks(input int n, input int max_cyc, output int got);
    int prev = -1;
    got = 0;
    for (int c = 1; c <= max_cyc && got < n; c++) begin
      @(negedge clk);
      if (tick) begin
        if (prev >= 0) begin
          ivl[got] = c - prev;
          got++;
        end
        prev = c;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int got;
    int tot;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 tick", tick, 0);
    check("R1 pending", upd_pending, 0);
    check("R1 int_rdata", int_rdata, 0);
    check("R1 frac_rdata", frac_rdata, 0);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); seen += tick; end
    check("R1 no ticks", seen, 0);

    // R2 readback
    wr_div(16'hBEEF, 6'h2A);
    check("R2 int_rdata", int_rdata, 16'hBEEF);
    check("R2 frac_rdata", frac_rdata, 32'h0000_002A);
    wr_div(16'h0003, 6'h3F);
    check("R2 frac_rdata max", frac_rdata, 32'h0000_003F);

    // vector table: R6, R7, R9 under idle commits (R4)
    for (int v = 0; v < NVEC; v++) begin
      wr_div(VEC[v][0], VEC[v][1]);
      commit_measure(1'b0, VEC[v][2], 2000, got);
      check("R9 tick count", got, VEC[v][2]);
      for (int k = 0; k < got; k++)
        check((k == 0) ? "R9 first period" : (VEC[v][1] == 0 ? "R6 period" : "R7 period"),
              ivl[k], exp_period(VEC[v][0], VEC[v][1], k));
      check("R4 pending after idle commit", upd_pending, 0);
    end

    // R7 total over 64 periods
    wr_div(3, 5);
    commit_measure(1'b0, 65, 2000, got);
    tot = 0;
    for (int k = 1; k < 65; k++) tot += ivl[k];
    check("R7 sum of 64 periods", tot, 64 * 3 + 5);

    // R4 same-edge commit
    wr_div(4, 0);
    lc_wr = 1'b1;
    @(negedge clk);
    lc_wr = 1'b0;
    check("R4 pending stays low", upd_pending, 0);

    // R3 staged write alone leaves rate unchanged
    wr_div(9, 40);
    watch_ticks(3, 200, got);
    check("R3 tick count", got, 3);
    for (int k = 0; k < 3; k++) check("R3 period unchanged", ivl[k], 4);

    // R5 deferred commit while a character is in flight
    char_busy = 1'b1;
    wr_div(7, 0);
    lc_wr = 1'b1;
    @(negedge clk);
    lc_wr = 1'b0;
    check("R5 pending set", upd_pending, 1);
    watch_ticks(3, 200, got);
    for (int k = 0; k < 3; k++) check("R5 old rate kept", ivl[k], 4);
    check("R5 still pending", upd_pending, 1);
    commit_measure(1'b1, 3, 200, got);
    check("R5 tick count", got, 3);
    for (int k = 0; k < 3; k++) check("R5 new rate after done", ivl[k], 7);
    check("R5 pending cleared", upd_pending, 0);
    char_busy = 1'b0;

    // R10 write and strobe at the same edge
    int_wr = 1'b1; int_wdata = 16'd6;
    frac_wr = 1'b1; frac_wdata = 6'd0;
    commit_measure(1'b0, 2, 200, got);
    check("R10 tick count", got, 2);
    check("R10 first period", ivl[0], 6);
    check("R10 second period", ivl[1], 6);

    // R8 zero divisor silences output
    wr_div(0, 12);
    lc_wr = 1'b1;
    @(negedge clk);
    lc_wr = 1'b0;
    seen = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); seen += tick; end
    check("R8 no ticks with zero divisor", seen, 0);

    // R1 reset again clears staged and active state
    wr_div(5, 5);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 int_rdata after reset", int_rdata, 0);
    seen = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); seen += tick; end
    check("R1 silent after reset", seen, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule